// File: doc/BRIEF.md
# Time-of-Day Alarm Matcher with Wildcard Fields

This block holds three alarm bytes for seconds, minutes and hours and compares them with the current time bytes. The compare happens only in the cycle in which the timekeeper signals that its once-per-second advance is complete. If all three fields agree, the block sets a sticky alarm flag. The interrupt request is that flag gated by an alarm-enable input. The host clears the flag by reading status.

An alarm byte whose two top bits are both 1 (0xC0 to 0xFF) is a wildcard and agrees with any current value. This allows the following alarm rates:
- a real value in every field gives one alarm per day;
- a wildcard hour gives one alarm per hour;
- wildcard hour and minute give one alarm per minute;
- three wildcards give one alarm every second.

The comparison is a plain full-byte equality. The block therefore works in either binary or BCD encoding, provided the alarm bytes use the same encoding as the time bytes. The PM bit (bit 7 of the hour in 12-hour mode) takes part in the comparison.

Top module: `tod_alarm_match`

## Requirements
- R1: After reset the flag and interrupt are 0, and all three alarm bytes hold 0x00, so a compare at 00:00:00 matches and any other time does not.
- R2: An alarm byte with bits [7:6] equal to 2'b11 matches any current byte in its field.
- R3: An alarm byte with bits [7:6] not both 1 matches only an identical current byte, all 8 bits including bit 7 (the PM bit of the hour).
- R4: When the update-done strobe is high and all three fields match, the flag is 1 from the next clock edge on.
- R5: Without the update-done strobe, the flag does not change on a matching time, and a set flag stays set while no status read occurs.
- R6: A status read (stat_rd high for one cycle) clears the flag at the next edge.
- R7: If a status read and a matching update occur in the same cycle, the flag ends up 1.
- R8: The interrupt output is 1 exactly when the flag is 1 and alarm enable is 1. A low enable does not stop the flag from being set.
- R9: An alarm write stores alm_wdata into the field chosen by alm_sel: 0 for seconds, 1 for minutes, 2 for hours. A write with alm_sel = 3 changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_done | input | 1 | One-cycle strobe: the time bytes have just advanced |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hr | input | 8 | Current hours byte (bit 7 = PM in 12-hour mode) |
| alm_wr | input | 1 | Alarm byte write strobe |
| alm_sel | input | 2 | Field select for the write: 0 sec, 1 min, 2 hr, 3 none |
| alm_wdata | input | 8 | Alarm byte write data |
| alm_en | input | 1 | Alarm interrupt enable |
| stat_rd | input | 1 | Host status read; clears the flag |
| alarm_flag | output | 1 | Sticky alarm-match flag |
| alarm_irq | output | 1 | Interrupt request |

## Verification
Each field is swept over all 256 alarm byte values, with the other two fields set to wildcards. Each alarm value is compared with the same value, with values that differ only in bit 0 or bit 7, and with fixed values. This separates a true wildcard decode (both top bits) from an equality compare and from a compare that drops the PM bit. Daily, hourly, per-minute and per-second patterns are then stepped through runs of consecutive times. These runs show that the alarm fires only at the times its wildcard rate allows. Separate cases cover the following:
- a match without the strobe;
- a read that coincides with a match;
- enable low while the flag is set;
- writes to the unused select code.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int BYTE_W   = 8;
  localparam int N_FIELDS = 3;
  localparam int SEL_W    = $clog2(N_FIELDS + 1);

  typedef enum logic [SEL_W-1:0] {
    FLD_SEC  = 2'd0,
    FLD_MIN  = 2'd1,
    FLD_HR   = 2'd2,
    FLD_NONE = 2'd3
  } field_sel_e;

  typedef logic [BYTE_W-1:0] tbyte_t;

  // Wildcard when both top bits of the alarm byte are set
  function automatic logic is_wild(tbyte_t a);
    return a[BYTE_W-1] & a[BYTE_W-2];
  endfunction

  function automatic logic field_hit(tbyte_t a, tbyte_t c);
    return is_wild(a) || (a == c);
  endfunction
endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs import tod_alarm_pkg::*; #(
  parameter tbyte_t RST_VAL = '0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr,
  input  logic [SEL_W-1:0]                 sel,
  input  tbyte_t                           wdata,
  output logic [N_FIELDS-1:0][BYTE_W-1:0]  alm_q
);
  for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
    tbyte_t q;
    always_ff @(posedge clk) begin
      if (!rst_n)                         q <= RST_VAL;
      else if (wr && sel == SEL_W'(i))    q <= wdata;
    end
    assign alm_q[i] = q;
  end
endmodule

// File: rtl/tod_field_match.sv
module tod_field_match import tod_alarm_pkg::*; (
  input  tbyte_t alm_byte,
  input  tbyte_t cur_byte,
  output logic   hit
);
  assign hit = field_hit(alm_byte, cur_byte);
endmodule

// File: rtl/tod_alarm_flag.sv
module tod_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic all_hit,
  input  logic rd,
  input  logic en,
  output logic flag,
  output logic irq
);
  logic set_evt;
  assign set_evt = tick & all_hit;

  // A set in the same cycle as a read wins, so no event is lost
  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (rd)      flag <= 1'b0;
  end

  assign irq = flag & en;
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match import tod_alarm_pkg::*; #(
  parameter tbyte_t ALARM_RST = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_done,
  input  logic [BYTE_W-1:0]  cur_sec,
  input  logic [BYTE_W-1:0]  cur_min,
  input  logic [BYTE_W-1:0]  cur_hr,
  input  logic               alm_wr,
  input  logic [SEL_W-1:0]   alm_sel,
  input  logic [BYTE_W-1:0]  alm_wdata,
  input  logic               alm_en,
  input  logic               stat_rd,
  output logic               alarm_flag,
  output logic               alarm_irq
);
  logic [N_FIELDS-1:0][BYTE_W-1:0] alm_q;
  logic [N_FIELDS-1:0][BYTE_W-1:0] cur_vec;
  logic [N_FIELDS-1:0]             fld_hit;
  logic                            all_hit;

  assign cur_vec[FLD_SEC] = cur_sec;
  assign cur_vec[FLD_MIN] = cur_min;
  assign cur_vec[FLD_HR]  = cur_hr;

  tod_alarm_regs #(.RST_VAL(ALARM_RST)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (alm_wr),
    .sel   (alm_sel),
    .wdata (alm_wdata),
    .alm_q (alm_q)
  );

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_cmp
    tod_field_match u_fm (
      .alm_byte (alm_q[i]),
      .cur_byte (cur_vec[i]),
      .hit      (fld_hit[i])
    );
  end

  assign all_hit = &fld_hit;

  tod_alarm_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (upd_done),
    .all_hit (all_hit),
    .rd      (stat_rd),
    .en      (alm_en),
    .flag    (alarm_flag),
    .irq     (alarm_irq)
  );
endmodule

// File: rtl/tod_alarm_match_chk.sv
module tod_alarm_match_chk (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_done,
  input logic             stat_rd,
  input logic             alm_en,
  input logic [7:0]       cur_sec,
  input logic [2:0][7:0]  alm_q,
  input logic [2:0]       fld_hit,
  input logic             alarm_flag,
  input logic             alarm_irq
);
  // R2
  wild_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_q[0][7:6] == 2'b11) |-> fld_hit[0]);
  // R2
  wild_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_q[1][7:6] == 2'b11) |-> fld_hit[1]);
  // R2
  wild_hr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_q[2][7:6] == 2'b11) |-> fld_hit[2]);
  // R3
  exact_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((alm_q[0][7:6] != 2'b11) && (alm_q[0] != cur_sec)) |-> !fld_hit[0]);
  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && (&fld_hit)) |=> alarm_flag);
  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_done && !stat_rd) |=> $stable(alarm_flag));
  // R6
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(upd_done && (&fld_hit))) |=> !alarm_flag);
  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alm_en |-> !alarm_irq);
  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> alarm_flag);
endmodule

bind tod_alarm_match tod_alarm_match_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_done   (upd_done),
  .stat_rd    (stat_rd),
  .alm_en     (alm_en),
  .cur_sec    (cur_sec),
  .alm_q      (alm_q),
  .fld_hit    (fld_hit),
  .alarm_flag (alarm_flag),
  .alarm_irq  (alarm_irq)
);

// File: tb/tod_alarm_match_test.sv
`timescale 1ns/1ps
module tod_alarm_match_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_done = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hr = '0;
  logic       alm_wr = 1'b0;
  logic [1:0] alm_sel = '0;
  logic [7:0] alm_wdata = '0;
  logic       alm_en = 1'b1;
  logic       stat_rd = 1'b0;
  logic       alarm_flag, alarm_irq;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  logic [7:0] a_sec, a_min, a_hr;

  always #10 clk = ~clk;

  tod_alarm_match uut (
    .clk(clk), .rst_n(rst_n), .upd_done(upd_done),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
    .alm_wr(alm_wr), .alm_sel(alm_sel), .alm_wdata(alm_wdata),
    .alm_en(alm_en), .stat_rd(stat_rd),
    .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
  );

  function automatic bit exp_hit(logic [7:0] a, logic [7:0] c);
    return (a >= 8'hC0) || (a == c);
  endfunction

  function automatic bit exp_all(logic [7:0] s, logic [7:0] m, logic [7:0] h);
    return exp_hit(a_sec, s) && exp_hit(a_min, m) && exp_hit(a_hr, h);
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b (alarm %h:%h:%h cur %h:%h:%h)",
               req, act, exp, a_hr, a_min, a_sec, cur_hr, cur_min, cur_sec);
    end
  endtask

  task automatic wr_alarm(logic [1:0] sel, logic [7:0] v);
    @(negedge clk);
    alm_wr = 1'b1; alm_sel = sel; alm_wdata = v;
    @(negedge clk);
    alm_wr = 1'b0;
    if (sel == 2'd0) a_sec = v;
    if (sel == 2'd1) a_min = v;
    if (sel == 2'd2) a_hr  = v;
  endtask

  task automatic set_alarm(logic [7:0] h, logic [7:0] m, logic [7:0] s);
    wr_alarm(2'd2, h); wr_alarm(2'd1, m); wr_alarm(2'd0, s);
  endtask

  // Clear the flag with a status read; ends on a negedge
  task automatic clr();
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  // One update strobe with the given time; flag sampled one edge later
  task automatic tick(string req, logic [7:0] h, logic [7:0] m, logic [7:0] s);
    bit e;
    @(negedge clk);
    cur_hr = h; cur_min = m; cur_sec = s; upd_done = 1'b1;
    e = exp_all(s, m, h);
    @(negedge clk);
    upd_done = 1'b0;
    check(req, alarm_flag, e);
    check("R8", alarm_irq, e && alm_en);
    if (alarm_flag) begin
      clr();
      check("R6", alarm_flag, 1'b0);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] vals [6];
    a_sec = 8'h00; a_min = 8'h00; a_hr = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", alarm_flag, 1'b0);
    check("R1", alarm_irq, 1'b0);
    tick("R1", 8'h00, 8'h00, 8'h01);
    tick("R1", 8'h00, 8'h00, 8'h00);

    // R2 R3: per-field sweep, other fields wildcarded
    for (int f = 0; f < 3; f++) begin
      set_alarm(8'hC0, 8'hC0, 8'hC0);
      for (int a = 0; a < 256; a++) begin
        wr_alarm(2'(f), 8'(a));
        vals[0] = 8'(a); vals[1] = 8'(a) ^ 8'h01; vals[2] = 8'(a) ^ 8'h80;
        vals[3] = 8'h00; vals[4] = 8'h59; vals[5] = 8'hFF;
        for (int k = 0; k < 6; k++) begin
          if (f == 0) tick("R2/R3", 8'h07, 8'h07, vals[k]);
          if (f == 1) tick("R2/R3", 8'h07, vals[k], 8'h07);
          if (f == 2) tick("R2/R3", vals[k], 8'h07, 8'h07);
        end
      end
    end

    // R4: daily alarm 12:30:45 BCD, stepping seconds
    set_alarm(8'h12, 8'h30, 8'h45);
    for (int s = 0; s < 60; s++)
      tick("R4", 8'h12, 8'h30, 8'((s / 10) * 16 + s % 10));
    tick("R3", 8'h92, 8'h30, 8'h45);   // PM bit differs
    tick("R4", 8'h12, 8'h31, 8'h45);
    // R4: hourly
    set_alarm(8'hC0, 8'h15, 8'h00);
    for (int h = 0; h < 24; h++) begin
      tick("R4", 8'(h), 8'h15, 8'h00);
      tick("R4", 8'(h), 8'h16, 8'h00);
    end
    // R4: per minute
    set_alarm(8'hFF, 8'hD3, 8'h30);
    for (int m = 0; m < 60; m++) begin
      tick("R4", 8'h03, 8'(m), 8'h30);
      tick("R4", 8'h03, 8'(m), 8'h31);
    end
    // R4: per second
    set_alarm(8'hE5, 8'hC0, 8'hFE);
    for (int s = 0; s < 60; s++) tick("R4", 8'h11, 8'h22, 8'(s));

    // R5: match present without strobe
    set_alarm(8'h01, 8'h02, 8'h03);
    @(negedge clk);
    cur_hr = 8'h01; cur_min = 8'h02; cur_sec = 8'h03;
    repeat (4) @(negedge clk);
    check("R5", alarm_flag, 1'b0);
    // R5: set flag stays without read
    @(negedge clk); upd_done = 1'b1;
    @(negedge clk); upd_done = 1'b0;
    repeat (5) @(negedge clk);
    check("R5", alarm_flag, 1'b1);
    // R7: read coinciding with matching update
    @(negedge clk); upd_done = 1'b1; stat_rd = 1'b1;
    @(negedge clk); upd_done = 1'b0; stat_rd = 1'b0;
    check("R7", alarm_flag, 1'b1);
    // R6: read with non-matching update clears
    cur_sec = 8'h04;
    @(negedge clk); upd_done = 1'b1; stat_rd = 1'b1;
    @(negedge clk); upd_done = 1'b0; stat_rd = 1'b0;
    check("R6", alarm_flag, 1'b0);

    // R8: enable low still sets flag, irq masked
    alm_en = 1'b0;
    cur_sec = 8'h03;
    @(negedge clk); upd_done = 1'b1;
    @(negedge clk); upd_done = 1'b0;
    check("R8", alarm_flag, 1'b1);
    check("R8", alarm_irq, 1'b0);
    alm_en = 1'b1;
    #1;
    check("R8", alarm_irq, 1'b1);
    clr();

    // R9: select 3 changes no field
    set_alarm(8'h00, 8'h00, 8'h00);
    @(negedge clk);
    alm_wr = 1'b1; alm_sel = 2'd3; alm_wdata = 8'hC0;
    @(negedge clk);
    alm_wr = 1'b0;
    tick("R9", 8'h00, 8'h00, 8'h05);
    tick("R9", 8'h00, 8'h05, 8'h00);
    tick("R9", 8'h05, 8'h00, 8'h00);
    tick("R9", 8'h00, 8'h00, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule